// File: doc/BRIEF.md
# Fault Flag Deglitch Reporter

This block drives the active-low fault indicator of one power-switch channel. Three fault inputs come in already synchronized to the system clock: overcurrent, reverse voltage and over-temperature. The indicator is an open-drain pin, so the block's only output is a pull-down enable. When that enable is 1 the pin is held low.

Overcurrent and reverse voltage each have their own qualification time. A fault must be present for that whole time before the indicator is pulled low. This keeps short events, such as a heavy capacitive load charging or an output voltage transient, from ever reaching the pin. The thermal input is treated as already filtered, so it takes effect on the first clock edge that sees it.

Once pulled low, the indicator stays low while any fault input is present. It is released only after every input has stayed clear for a separate release time. All times are given in microseconds and turned into clock cycles through a system clock frequency parameter.

Top module: `fault_flag_reporter`

## Requirements
- R1: When `rst_n` is sampled low on a rising edge, `flag_pulldown` is 0 after that edge and every qualification and release count restarts from zero. After reset is released, an overcurrent input that stays high needs a full `OC_CYC` edges again before the indicator is pulled low.
- R2: `OC_CYC` = max(1, `CLK_HZ`/1000000 × `OC_QUAL_US`). While `flag_pulldown` is 0, it becomes 1 right after the `OC_CYC`-th consecutive rising edge at which `oc_fault` is sampled 1.
- R3: `RV_CYC` = max(1, `CLK_HZ`/1000000 × `RV_QUAL_US`). While `flag_pulldown` is 0, it becomes 1 right after the `RV_CYC`-th consecutive rising edge at which `rv_fault` is sampled 1.
- R4: `flag_pulldown` becomes 1 right after the first rising edge at which `ot_fault` is sampled 1.
- R5: An overcurrent or reverse-voltage fault that is sampled high on fewer consecutive edges than its own qualification count leaves `flag_pulldown` at 0. One low sample restarts that count from zero, so several such pulses separated by gaps never add up.
- R6: While `flag_pulldown` is 1, it stays 1 after every edge at which any fault input is sampled 1, whether or not that fault has qualified.
- R7: `REL_CYC` = max(1, `CLK_HZ`/1000000 × `REL_US`). `flag_pulldown` returns to 0 right after the `REL_CYC`-th consecutive edge at which all three fault inputs are sampled 0.
- R8: If any fault input is sampled 1 during the release interval, the release count restarts. A full `REL_CYC` clear edges are then needed, counted from after that sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| oc_fault | input | 1 | Overcurrent comparator, synchronized, 1 = fault |
| rv_fault | input | 1 | Reverse-voltage comparator, synchronized, 1 = fault |
| ot_fault | input | 1 | Over-temperature indication, filtered, 1 = fault |
| flag_pulldown | output | 1 | Open-drain enable, 1 = pull the fault pin low |

## Verification
The bench builds the block with `CLK_HZ` = 1000000 so that one microsecond is one cycle. The times it uses are `OC_QUAL_US` = 6, `RV_QUAL_US` = 4 and `REL_US` = 3. With these values it can apply every pulse length from one edge up to three edges past each cause's qualification count, and compare each cycle with a closed-form expected window. The release interval is short enough to inject a fault on every possible clear-edge position inside it. The tests also cover overlapping causes and a reset taken in the middle of a qualification.

// File: rtl/fflag_pkg.sv
// Package: shared constants and helpers for the fault flag reporter.
// Assumes durations are given in whole microseconds and CLK_HZ is a
// multiple of 1 MHz; any result below one cycle is rounded up to one.
package fflag_pkg;

    // Index of each fault cause inside the cause vector.
    typedef enum int {
        CAUSE_OC = 0,
        CAUSE_RV = 1,
        CAUSE_OT = 2
    } cause_e;

    localparam int NUM_CAUSES = 3;

    // Convert a duration in microseconds to clock cycles, minimum one.
    function automatic int us_to_cycles(input int clk_hz, input int dur_us);
        int cyc;
        cyc = (clk_hz / 1000000) * dur_us;
        return (cyc < 1) ? 1 : cyc;
    endfunction

endpackage

// File: rtl/persist_timer.sv
// Module: persist_timer
// Reports "met" on the CYCLES-th consecutive edge at which "level" is 1.
// "met" is combinational from the running count and the current level, so
// a register fed by it is updated on that same edge. Any low sample or
// reset clears the count. Assumes CYCLES >= 1.
module persist_timer #(
    parameter int CYCLES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic met
);

    generate
        if (CYCLES == 1) begin : g_direct
            // A single-cycle requirement needs no counter.
            assign met = level;
        end else begin : g_count
            localparam int W = $clog2(CYCLES);
            localparam logic [W-1:0] LAST = W'(CYCLES - 1);

            logic [W-1:0] run_cnt;

            // Count consecutive high samples, holding at the last value.
            always_ff @(posedge clk) begin
                if (!rst_n || !level) begin
                    run_cnt <= '0;
                end else if (run_cnt != LAST) begin
                    run_cnt <= run_cnt + 1'b1;
                end
            end

            assign met = level && (run_cnt == LAST);
        end
    endgenerate

endmodule

// File: rtl/fault_qual_bank.sv
// Module: fault_qual_bank
// Gives each fault cause its own persistence timer with a qualification
// length chosen per cause. Assumes the raw inputs are already synchronous.
module fault_qual_bank
    import fflag_pkg::*;
#(
    parameter int OC_CYC = 1,
    parameter int RV_CYC = 1,
    parameter int OT_CYC = 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_CAUSES-1:0] raw,
    output logic [NUM_CAUSES-1:0] qualified
);

    generate
        for (genvar i = 0; i < NUM_CAUSES; i++) begin : g_cause
            localparam int QC = (i == CAUSE_OC) ? OC_CYC :
                                (i == CAUSE_RV) ? RV_CYC : OT_CYC;

            // One persistence timer per cause.
            persist_timer #(.CYCLES(QC)) u_tmr (
                .clk   (clk),
                .rst_n (rst_n),
                .level (raw[i]),
                .met   (qualified[i])
            );
        end
    endgenerate

endmodule

// File: rtl/fault_flag_reporter.sv
// Module: fault_flag_reporter (top)
// Drives the open-drain enable of one channel's active-low fault pin.
// The pin is pulled low once any cause qualifies. It is released after all
// causes have stayed clear for the release time. Over-temperature is taken
// as pre-filtered, so it gets a one-cycle qualification.
module fault_flag_reporter
    import fflag_pkg::*;
#(
    parameter int CLK_HZ     = 50000000,
    parameter int OC_QUAL_US = 7000,
    parameter int RV_QUAL_US = 5000,
    parameter int REL_US     = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic oc_fault,
    input  logic rv_fault,
    input  logic ot_fault,
    output logic flag_pulldown
);

    localparam int OC_CYC  = us_to_cycles(CLK_HZ, OC_QUAL_US);
    localparam int RV_CYC  = us_to_cycles(CLK_HZ, RV_QUAL_US);
    localparam int REL_CYC = us_to_cycles(CLK_HZ, REL_US);

    logic [NUM_CAUSES-1:0] raw_vec;
    logic [NUM_CAUSES-1:0] qual_vec;
    logic                  held;
    logic                  clear_level;
    logic                  release_met;

    // Gather the causes into index order.
    always_comb begin
        raw_vec           = '0;
        raw_vec[CAUSE_OC] = oc_fault;
        raw_vec[CAUSE_RV] = rv_fault;
        raw_vec[CAUSE_OT] = ot_fault;
    end

    // Qualify each cause over its own time.
    fault_qual_bank #(
        .OC_CYC (OC_CYC),
        .RV_CYC (RV_CYC),
        .OT_CYC (1)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .raw       (raw_vec),
        .qualified (qual_vec)
    );

    // The release timer runs only while the pin is held and nothing is raw.
    assign clear_level = held && (raw_vec == '0);

    persist_timer #(.CYCLES(REL_CYC)) u_release (
        .clk   (clk),
        .rst_n (rst_n),
        .level (clear_level),
        .met   (release_met)
    );

    // Hold state: set on any qualified cause, cleared when release completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= 1'b0;
        end else if (|qual_vec) begin
            held <= 1'b1;
        end else if (release_met) begin
            held <= 1'b0;
        end
    end

    assign flag_pulldown = held;

endmodule

// File: rtl/fault_flag_checker.sv
// Module: fault_flag_checker
// Port-level checks on the reporter. It keeps its own run counters of the
// inputs and does not look at any internal signal of the design.
module fault_flag_checker
    import fflag_pkg::*;
#(
    parameter int CLK_HZ     = 50000000,
    parameter int OC_QUAL_US = 7000,
    parameter int RV_QUAL_US = 5000,
    parameter int REL_US     = 5000
) (
    input logic clk,
    input logic rst_n,
    input logic oc_fault,
    input logic rv_fault,
    input logic ot_fault,
    input logic flag_pulldown
);

    localparam int OC_CYC  = us_to_cycles(CLK_HZ, OC_QUAL_US);
    localparam int RV_CYC  = us_to_cycles(CLK_HZ, RV_QUAL_US);
    localparam int REL_CYC = us_to_cycles(CLK_HZ, REL_US);
    localparam int CAP     = 1 << 30;

    logic any_fault;
    int   oc_run;
    int   rv_run;
    int   clr_run;
    logic armed;
    logic rst_seen_low;

    assign any_fault = oc_fault || rv_fault || ot_fault;

    // Count consecutive sampled-high and all-clear edges since reset.
    always_ff @(posedge clk) begin
        oc_run       <= (!rst_n || !oc_fault) ? 0 : ((oc_run < CAP) ? oc_run + 1 : oc_run);
        rv_run       <= (!rst_n || !rv_fault) ? 0 : ((rv_run < CAP) ? rv_run + 1 : rv_run);
        clr_run      <= (!rst_n || any_fault) ? 0 : ((clr_run < CAP) ? clr_run + 1 : clr_run);
        rst_seen_low <= !rst_n;
        armed        <= 1'b1;
    end

    // The edge after a reset edge must show the released state.
    always @(posedge clk) begin
        if (armed && rst_seen_low) begin
            AST_RESET_RELEASED: assert (!flag_pulldown); // R1
        end
    end

    AST_OT_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
        ot_fault |=> flag_pulldown); // R4

    AST_QUAL_TIME_MET: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(flag_pulldown) && $past(rst_n)) |->
            ($past(ot_fault) || oc_run >= OC_CYC || rv_run >= RV_CYC)); // R2, R3

    AST_NO_ASSERT_WITHOUT_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_pulldown && !any_fault) |=> !flag_pulldown); // R5

    AST_HOLD_WHILE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_pulldown && any_fault) |=> flag_pulldown); // R6

    AST_RELEASE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(flag_pulldown) && $past(rst_n)) |-> (clr_run >= REL_CYC)); // R7

endmodule

bind fault_flag_reporter fault_flag_checker #(
    .CLK_HZ     (CLK_HZ),
    .OC_QUAL_US (OC_QUAL_US),
    .RV_QUAL_US (RV_QUAL_US),
    .REL_US     (REL_US)
) u_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .oc_fault      (oc_fault),
    .rv_fault      (rv_fault),
    .ot_fault      (ot_fault),
    .flag_pulldown (flag_pulldown)
);

// File: tb/fault_flag_reporter_test.sv
`timescale 1ns/1ps
// Bench: sweeps pulse lengths per cause and fault positions inside the
// release window. Expected values come from closed-form windows.
module fault_flag_reporter_test;

    localparam int QOC = 6;   // 1 MHz x 6 us
    localparam int QRV = 4;   // 1 MHz x 4 us
    localparam int QOT = 1;
    localparam int REL = 3;   // 1 MHz x 3 us

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic oc = 1'b0, rv = 1'b0, ot = 1'b0;
    logic flag_pulldown;
    int   total = 0;
    int   bad = 0;

    always #10 clk = ~clk;

    fault_flag_reporter #(
        .CLK_HZ     (1000000),
        .OC_QUAL_US (QOC),
        .RV_QUAL_US (QRV),
        .REL_US     (REL)
    ) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .oc_fault      (oc),
        .rv_fault      (rv),
        .ot_fault      (ot),
        .flag_pulldown (flag_pulldown)
    );

    // Apply inputs for one edge, then compare after the edge at the negedge.
    task automatic step(input logic o, input logic r, input logic t,
                        input logic exp, input string tag);
        oc = o; rv = r; ot = t;
        @(negedge clk);
        total++;
        if (flag_pulldown !== exp) begin
            bad++;
            $display("FAIL %s t=%0t: flag_pulldown=%0b expected=%0b", tag, $time, flag_pulldown, exp);
        end
    endtask

    // Settle to the released state.
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, 1'b0, "R7 idle");
    endtask

    function automatic int qual_of(input int c);
        return (c == 0) ? QOC : (c == 1) ? QRV : QOT;
    endfunction

    // Pulse of length L on cause c; window [Q-1, L+REL-2] when L >= Q.
    task automatic pulse(input int c, input int len);
        int    q;
        logic  exp;
        string tag;
        q = qual_of(c);
        for (int e = 0; e < len + REL + 2; e++) begin
            exp = (len >= q) && (e >= q - 1) && (e <= len + REL - 2);
            if (e >= len)      tag = "R7 release";
            else if (len < q)  tag = "R5 short";
            else if (c == 0)   tag = "R2 oc";
            else if (c == 1)   tag = "R3 rv";
            else               tag = "R4 ot";
            step(e < len && c == 0, e < len && c == 1, e < len && c == 2, exp, tag);
        end
    endtask

    initial begin
        #4000000;
        total++;
        bad++;
        $display("FAIL watchdog: finished=0 expected=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        step(1'b0, 1'b0, 1'b0, 1'b0, "R1 reset");
        step(1'b0, 1'b0, 1'b1, 1'b0, "R1 reset with ot");
        rst_n = 1'b1;
        idle(2);

        // Sweep pulse lengths for every cause.
        for (int c = 0; c < 3; c++) begin
            for (int len = 1; len <= qual_of(c) + 3; len++) begin
                pulse(c, len);
            end
        end

        // R5: short pulses separated by one clear edge never add up.
        for (int k = 0; k < 3; k++) begin
            for (int e = 0; e < QOC - 1; e++) step(1'b1, 1'b0, 1'b0, 1'b0, "R5 oc restart");
            step(1'b0, 1'b0, 1'b0, 1'b0, "R5 oc gap");
        end
        for (int k = 0; k < 3; k++) begin
            for (int e = 0; e < QRV - 1; e++) step(1'b0, 1'b1, 1'b0, 1'b0, "R5 rv restart");
            step(1'b0, 1'b0, 1'b0, 1'b0, "R5 rv gap");
        end

        // R8: a one-edge fault at every gap inside the release window.
        for (int c = 0; c < 3; c++) begin
            for (int g = 1; g < REL; g++) begin
                step(1'b0, 1'b0, 1'b1, 1'b1, "R4 set");
                for (int j = 0; j < g; j++) step(1'b0, 1'b0, 1'b0, 1'b1, "R8 gap");
                step(c == 0, c == 1, c == 2, 1'b1, "R8 blip");
                for (int j = 1; j <= REL + 1; j++)
                    step(1'b0, 1'b0, 1'b0, j < REL, "R8 restarted");
            end
        end

        // R6: overlapping causes; rv qualifies first, oc keeps it held.
        for (int e = 0; e < 11 + REL + 2; e++) begin
            step(e < 11, e < 6, 1'b0, (e >= QRV - 1) && (e <= 11 + REL - 2), "R6 overlap");
        end

        // R1: reset mid-hold clears state and the oc count.
        for (int e = 0; e < QOC; e++) step(1'b1, 1'b0, 1'b0, e == QOC - 1, "R2 pre-reset");
        rst_n = 1'b0;
        step(1'b1, 1'b0, 1'b0, 1'b0, "R1 reset mid-hold");
        rst_n = 1'b1;
        for (int e = 0; e < QOC; e++) step(1'b1, 1'b0, 1'b0, e == QOC - 1, "R1 count cleared");
        for (int j = 1; j <= REL + 1; j++) step(1'b0, 1'b0, 1'b0, j < REL, "R7 after reset");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule